// File: doc/BRIEF.md
# Tagged Register Status Table

This block is the register file of a dynamically scheduled pipeline. Each architectural register carries a data value, a ready flag and the tag of the operation that will produce its next value. When an operation dispatches, every source operand is looked up in the same cycle. The lookup returns either a finished value or the tag of a pending producer, so the dispatch stage never has to stall on a missing operand.

An operation that writes a register takes the next tag from an internal wrapping counter. Its destination entry then becomes pending under that tag. Finished results arrive on a shared result bus as a tag/value pair. Every pending entry compares its own tag with the broadcast tag. A matching entry takes the value and becomes ready. A source lookup made in the same cycle as a matching broadcast also sees the broadcast value.

Dispatch and broadcast share one clock. The read outputs are combinational from the current state and the inputs of the same cycle. State changes at the next rising edge.

Top module: `regtag_table`

## Requirements
- R1: After reset every entry is ready and holds the value 0, and the tag counter is 0.
- R2: A dispatch with `disp_valid`=1 and `disp_wr`=1 makes the destination entry pending from the next cycle, with its tag set to the `disp_tag` value shown during that dispatch.
- R3: A lookup of a ready entry returns `src_ready`=1 and the stored value on that source's `src_data` slice.
- R4: A lookup of a pending entry with no matching broadcast in that cycle returns `src_ready`=0. The pending tag appears in the low TAG_W bits of the slice, and the upper bits are 0.
- R5: A broadcast (`res_valid`=1) whose tag equals a pending entry's tag makes that entry ready with `res_data` from the next cycle.
- R6: A broadcast whose tag differs from an entry's current tag leaves that entry unchanged. This includes a result for an older tag after the register has been given a newer one.
- R7: With FORWARD=1, a lookup of a pending entry whose tag equals the broadcast tag in the same cycle returns `src_ready`=1 and `res_data`.
- R8: When a dispatch reads and writes the same register, its lookups see the entry's state from before that dispatch.
- R9: `disp_tag` starts at 0 and advances by one, modulo 2^TAG_W, only after a dispatch that writes a register. A dispatch with `disp_wr`=0 uses no tag.
- R10: If a dispatch writes an entry in the same cycle that a matching broadcast arrives for it, the dispatch wins: the entry stays pending, takes the new tag and keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_valid | input | 1 | A dispatch takes place this cycle |
| disp_wr | input | 1 | The dispatching operation writes a destination register |
| disp_dst | input | IDX_W | Destination register index |
| disp_src | input | NUM_SRC*IDX_W | Source register indices; source k is bits [k*IDX_W +: IDX_W] |
| disp_tag | output | TAG_W | Tag given to a writing dispatch in this cycle |
| src_ready | output | NUM_SRC | Per source: 1 = value, 0 = pending tag |
| src_data | output | NUM_SRC*DATA_W | Per source: the value, or the zero-extended tag |
| res_valid | input | 1 | A result is broadcast this cycle |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_data | input | DATA_W | Value of the broadcast result |

## Verification
The assertions assume that all inputs are known after reset. They also assume that register indices are below NUM_REGS, which is always true when NUM_REGS is a power of two. The bench model further relies on no two pending entries sharing a tag. To keep to this, the stimulus drops the write of a random dispatch whenever the next tag is still held by another pending register. Broadcasts mostly carry the tag of a chosen pending register, with some unrelated tags mixed in so that non-matching results are exercised.

// File: rtl/regtag_pkg.sv
package regtag_pkg;
   typedef enum logic [1:0] {
      SRC_VALUE   = 2'd0,
      SRC_FORWARD = 2'd1,
      SRC_PENDING = 2'd2
   } src_kind_e;
endpackage

// File: rtl/regtag_alloc.sv
module regtag_alloc #(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   output logic [TAG_W-1:0] tag_o
);
   logic [TAG_W-1:0] next_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    next_q <= '0;
      else if (take) next_q <= next_q + TAG_W'(1);
   end

   assign tag_o = next_q;

   // R9: one step per writing dispatch, no step otherwise
   p_tag_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> tag_o == $past(tag_o) + TAG_W'(1));
   p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(tag_o));
endmodule

// File: rtl/regtag_entry.sv
module regtag_entry #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              valid_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [DATA_W-1:0] value_o
);
   logic              valid_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] value_q;
   logic              hit;

   assign hit = bc_valid && !valid_q && (bc_tag == tag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b1;
         tag_q   <= '0;
         value_q <= '0;
      end else if (alloc_en) begin
         valid_q <= 1'b0;
         tag_q   <= alloc_tag;
      end else if (hit) begin
         valid_q <= 1'b1;
         value_q <= bc_data;
      end
   end

   assign valid_o = valid_q;
   assign tag_o   = tag_q;
   assign value_o = value_q;

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (valid_o && value_o == '0));
   p_alloc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> (!valid_o && tag_o == $past(alloc_tag)));
   p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && !valid_o && bc_tag == tag_o && !alloc_en)
      |=> (valid_o && value_o == $past(bc_data)));
   p_stale_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_en && !(bc_valid && bc_tag == tag_o))
      |=> ($stable(value_o) && $stable(tag_o) && $stable(valid_o)));
   p_alloc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && bc_valid && !valid_o && bc_tag == tag_o)
      |=> (!valid_o && $stable(value_o)));
endmodule

// File: rtl/regtag_rdport.sv
module regtag_rdport
   import regtag_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   parameter bit FORWARD  = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]           idx,
   input  logic [NUM_REGS-1:0]        vld_vec,
   input  logic [NUM_REGS*TAG_W-1:0]  tag_flat,
   input  logic [NUM_REGS*DATA_W-1:0] val_flat,
   input  logic                       bc_valid,
   input  logic [TAG_W-1:0]           bc_tag,
   input  logic [DATA_W-1:0]          bc_data,
   output logic                       ready_o,
   output logic [DATA_W-1:0]          data_o
);
   logic              sel_vld;
   logic [TAG_W-1:0]  sel_tag;
   logic [DATA_W-1:0] sel_val;
   src_kind_e         kind;

   assign sel_vld = vld_vec[idx];
   assign sel_tag = tag_flat[idx*TAG_W +: TAG_W];
   assign sel_val = val_flat[idx*DATA_W +: DATA_W];

   if (FORWARD) begin : g_fwd
      always_comb begin
         if (sel_vld)                              kind = SRC_VALUE;
         else if (bc_valid && bc_tag == sel_tag)   kind = SRC_FORWARD;
         else                                      kind = SRC_PENDING;
      end
   end else begin : g_nofwd
      logic unused_bc;
      assign unused_bc = bc_valid ^ (^bc_tag);
      always_comb kind = sel_vld ? SRC_VALUE : SRC_PENDING;
   end

   always_comb begin
      unique case (kind)
         SRC_VALUE:   begin ready_o = 1'b1; data_o = sel_val; end
         SRC_FORWARD: begin ready_o = 1'b1; data_o = bc_data; end
         default:     begin ready_o = 1'b0; data_o = DATA_W'(sel_tag); end
      endcase
   end
endmodule

// File: rtl/regtag_table.sv
module regtag_table #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 4,
   parameter int NUM_SRC  = 2,
   parameter bit FORWARD  = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      disp_valid,
   input  logic                      disp_wr,
   input  logic [IDX_W-1:0]          disp_dst,
   input  logic [NUM_SRC*IDX_W-1:0]  disp_src,
   output logic [TAG_W-1:0]          disp_tag,
   output logic [NUM_SRC-1:0]        src_ready,
   output logic [NUM_SRC*DATA_W-1:0] src_data,
   input  logic                      res_valid,
   input  logic [TAG_W-1:0]          res_tag,
   input  logic [DATA_W-1:0]         res_data
);
   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("regtag_table: NUM_REGS must be a power of two of at least 2");
   end
   if (TAG_W < 1 || TAG_W > DATA_W) begin : g_bad_tag
      $error("regtag_table: TAG_W must lie in 1..DATA_W");
   end
   if (NUM_SRC < 1) begin : g_bad_src
      $error("regtag_table: NUM_SRC must be at least 1");
   end

   logic                       take;
   logic [NUM_REGS-1:0]        vld_vec;
   logic [NUM_REGS*TAG_W-1:0]  tag_flat;
   logic [NUM_REGS*DATA_W-1:0] val_flat;

   assign take = disp_valid && disp_wr;

   regtag_alloc #(.TAG_W(TAG_W)) u_alloc (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .tag_o (disp_tag)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      logic hit_dst;
      assign hit_dst = take && (disp_dst == IDX_W'(i));
      regtag_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_en  (hit_dst),
         .alloc_tag (disp_tag),
         .bc_valid  (res_valid),
         .bc_tag    (res_tag),
         .bc_data   (res_data),
         .valid_o   (vld_vec[i]),
         .tag_o     (tag_flat[i*TAG_W +: TAG_W]),
         .value_o   (val_flat[i*DATA_W +: DATA_W])
      );
   end

   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      regtag_rdport #(
         .NUM_REGS (NUM_REGS),
         .DATA_W   (DATA_W),
         .TAG_W    (TAG_W),
         .FORWARD  (FORWARD)
      ) u_rd (
         .idx      (disp_src[k*IDX_W +: IDX_W]),
         .vld_vec  (vld_vec),
         .tag_flat (tag_flat),
         .val_flat (val_flat),
         .bc_valid (res_valid),
         .bc_tag   (res_tag),
         .bc_data  (res_data),
         .ready_o  (src_ready[k]),
         .data_o   (src_data[k*DATA_W +: DATA_W])
      );
   end

   // R4: a source that is not ready carries only a tag, so its upper bits are zero
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
      if (TAG_W < DATA_W) begin : g_hi
         p_tag_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !src_ready[k] |-> src_data[k*DATA_W+TAG_W +: DATA_W-TAG_W] == '0);
      end
   end
endmodule

// File: tb/sim_regtag_table.sv
module sim_regtag_table;
   localparam int NR = 16;
   localparam int DW = 32;
   localparam int TW = 4;
   localparam int NS = 2;
   localparam int IW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           disp_valid, disp_wr;
   logic [IW-1:0]  disp_dst;
   logic [NS*IW-1:0] disp_src;
   logic [TW-1:0]  disp_tag;
   logic [NS-1:0]  src_ready;
   logic [NS*DW-1:0] src_data;
   logic           res_valid;
   logic [TW-1:0]  res_tag;
   logic [DW-1:0]  res_data;
   logic [IW-1:0]  d_src [NS];

   always #4 clk = ~clk;

   for (genvar k = 0; k < NS; k++) begin : g_pack
      assign disp_src[k*IW +: IW] = d_src[k];
   end

   regtag_table #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .NUM_SRC(NS)) u0 (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_wr(disp_wr),
      .disp_dst(disp_dst), .disp_src(disp_src), .disp_tag(disp_tag),
      .src_ready(src_ready), .src_data(src_data), .res_valid(res_valid),
      .res_tag(res_tag), .res_data(res_data));

   logic          m_vld [NR];
   logic [TW-1:0] m_tag [NR];
   logic [DW-1:0] m_val [NR];
   logic [TW-1:0] m_next;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic logic [DW:0] exp_src(input logic [IW-1:0] r);
      if (m_vld[r]) return {1'b1, m_val[r]};
      if (res_valid && res_tag == m_tag[r]) return {1'b1, res_data};
      return {1'b0, DW'(m_tag[r])};
   endfunction

   function automatic string auto_lbl(input logic [IW-1:0] r);
      if (m_vld[r]) return "R3";
      if (res_valid && res_tag == m_tag[r]) return "R7";
      return "R4";
   endfunction

   task automatic check_now(input string lbl);
      for (int k = 0; k < NS; k++) begin
         logic [DW:0] e;
         string l;
         e = exp_src(d_src[k]);
         l = (lbl == "") ? auto_lbl(d_src[k]) : lbl;
         checks++;
         if ({src_ready[k], src_data[k*DW +: DW]} !== e) begin
            errors++;
            $display("FAIL %s src%0d reg %0d: ready %0b data %h, expected ready %0b data %h",
                     l, k, d_src[k], src_ready[k], src_data[k*DW +: DW], e[DW], e[DW-1:0]);
         end
      end
      checks++;
      if (disp_tag !== m_next) begin
         errors++;
         $display("FAIL R9 disp_tag: actual %0d expected %0d", disp_tag, m_next);
      end
   endtask

   task automatic model_step();
      bit take;
      take = disp_valid && disp_wr;
      for (int i = 0; i < NR; i++) begin
         if (take && disp_dst == IW'(i)) begin
            m_vld[i] = 1'b0;
            m_tag[i] = m_next;
         end else if (res_valid && !m_vld[i] && m_tag[i] == res_tag) begin
            m_vld[i] = 1'b1;
            m_val[i] = res_data;
         end
      end
      if (take) m_next = m_next + TW'(1);
   endtask

   task automatic cyc(input bit v, input bit w, input int dst, input int s0, input int s1,
                      input bit rv, input int rt, input logic [DW-1:0] rd, input string lbl);
      @(negedge clk);
      disp_valid = v; disp_wr = w; disp_dst = IW'(dst);
      d_src[0] = IW'(s0); d_src[1] = IW'(s1);
      res_valid = rv; res_tag = TW'(rt); res_data = rd;
      #2;
      check_now(lbl);
      @(posedge clk);
      model_step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      disp_valid = 0; disp_wr = 0; disp_dst = '0; d_src[0] = '0; d_src[1] = '0;
      res_valid = 0; res_tag = '0; res_data = '0;
      for (int i = 0; i < NR; i++) begin
         m_vld[i] = 1'b1; m_tag[i] = '0; m_val[i] = '0;
      end
      m_next = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      cyc(0, 0, 0, 0, 5, 0, 0, 0, "R1");                 // reset state
      cyc(1, 1, 3, 3, 3, 0, 0, 0, "R8");                 // read before re-tag
      cyc(1, 1, 3, 3, 7, 0, 0, 0, "");                   // R2: r3 pending tag 0
      cyc(0, 0, 0, 3, 3, 1, 0, 32'hAA, "R6");            // old tag 0 ignored, r3 now tag 1
      cyc(0, 0, 0, 3, 0, 1, 1, 32'hBB, "R7");            // forward in same cycle
      cyc(0, 0, 0, 3, 3, 0, 0, 0, "R5");                 // r3 now ready with BB
      cyc(1, 1, 4, 4, 3, 0, 0, 0, "R3");                 // r4 gets tag 2
      cyc(1, 1, 4, 4, 4, 1, 2, 32'hCC, "R7");            // r4 re-tagged 3 as tag 2 arrives
      cyc(0, 0, 0, 4, 4, 0, 0, 0, "R10");                // r4 still pending with tag 3
      cyc(1, 0, 5, 4, 5, 0, 0, 0, "R9");                 // no write: no tag used
      cyc(0, 0, 0, 5, 4, 0, 0, 0, "R9");

      for (int n = 0; n < 3000; n++) begin
         bit v, w, rv;
         int dst, rt, pick;
         v = ($urandom % 4) != 0;
         w = ($urandom % 3) != 0;
         dst = $urandom % NR;
         for (int i = 0; i < NR; i++)
            if (i != dst && !m_vld[i] && m_tag[i] == m_next) w = 0;
         rv = ($urandom % 2) != 0;
         pick = $urandom % NR;
         rt = (!m_vld[pick] && ($urandom % 5) != 0) ? int'(m_tag[pick]) : int'($urandom % (1 << TW));
         cyc(v, w, dst, $urandom % NR, $urandom % NR, rv, rt, $urandom, "");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule